// File: doc/BRIEF.md
# Maskable Interrupt Acknowledge Sequencer

This block sits between a processor core and its bus unit and turns a level-sensitive maskable interrupt request into a locked pair of interrupt acknowledge bus cycles. The request line carries no edge detection: it is looked at only when the core strobes an instruction boundary, and only if the interrupt-enable flag is set at that moment. If the request is gone by then, nothing happens.

Once a request is accepted, the sequencer commits to it. It raises a bus-cycle request marked as the first acknowledge cycle and holds it until the bus unit returns ready. It then moves straight into the second acknowledge cycle without a gap. The bus lock output covers both cycles and every wait state between them. At the ready of the second cycle the low byte of the data bus is latched as the interrupt vector, and a one-clock valid pulse announces it. Acknowledge cycles are always flagged as non-cacheable.

Top module: `intack_seq`

## Requirements
- R1: While and right after synchronous reset, `bus_req`, `bus_lock`, `bus_nocache` and `vec_valid` are 0, `bus_kind` is 0 and `vec_data` is 0.
- R2: When idle, a clock edge with `insn_bnd`, `ien` and `irq_lvl` all high starts the first acknowledge cycle: after that edge `bus_req`=1, `bus_kind`=1 (first acknowledge) and `bus_lock`=1.
- R3: With `ien` low, a request at an instruction boundary is ignored: `bus_req` stays 0 and `vec_valid` stays 0.
- R4: The request is seen only at an instruction boundary: a request that is high while `insn_bnd` is low, and low again when `insn_bnd` comes, starts no cycle.
- R5: Once the first acknowledge cycle has started, dropping `irq_lvl` or `ien` does not stop it; both cycles complete.
- R6: The first cycle holds `bus_req`=1 and `bus_kind`=1 through any number of clocks with `bus_rdy` low; the clock edge on which `bus_rdy` is high moves it directly to `bus_kind`=2 (second acknowledge) with `bus_req` still 1.
- R7: `bus_lock` is 1 in every clock of both acknowledge cycles, including wait states, and is 0 in the clock after the second cycle's ready edge.
- R8: At the edge where `bus_rdy` is high during the second cycle, `bus_data[7:0]` is captured into `vec_data` and `vec_valid` is 1 for exactly the following clock; data returned in the first cycle is never captured.
- R9: `bus_nocache` is 1 whenever `bus_req` is 1.
- R10: `vec_data` keeps the last captured vector until the next second-cycle ready edge; requests that are ignored leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lvl | input | 1 | Level-sensitive maskable interrupt request |
| ien | input | 1 | Interrupt-enable flag from the core |
| insn_bnd | input | 1 | Instruction boundary strobe, one clock |
| bus_rdy | input | 1 | Bus unit ready, ends the current cycle |
| bus_data | input | VEC_W (8) | Low byte lane of the read data bus |
| bus_req | output | 1 | Bus cycle requested |
| bus_kind | output | 2 | Cycle type: 0 none, 1 first acknowledge, 2 second acknowledge |
| bus_lock | output | 1 | Bus lock, held across both acknowledge cycles |
| bus_nocache | output | 1 | Marks the current cycle as non-cacheable |
| vec_valid | output | 1 | One-clock pulse: new vector captured |
| vec_data | output | VEC_W (8) | Last captured interrupt vector |

## Verification
Every result of this block is due exactly one clock edge after its cause: the first cycle appears one edge after the accepting boundary, the second cycle one edge after the first ready, and the vector, its valid pulse and the lock release one edge after the second ready. The bench drives all inputs at the falling edge, lets a single rising edge pass, and checks the outputs at the next falling edge, so each check lands on the cycle in which its result is due. Wait states are inserted with the ready line low, and the checks repeat on every waiting clock to show the cycle type and lock holding still.

// File: rtl/intack_pkg.sv
package intack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } ack_state_t;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_INTA1 = 2'd1,
        CYC_INTA2 = 2'd2
    } cyc_kind_t;

    localparam int KIND_W = $bits(cyc_kind_t);

    function automatic cyc_kind_t kind_of(input ack_state_t st);
        case (st)
            ST_FIRST:  return CYC_INTA1;
            ST_SECOND: return CYC_INTA2;
            default:   return CYC_NONE;
        endcase
    endfunction

    function automatic logic in_ack(input ack_state_t st);
        return (st == ST_FIRST) || (st == ST_SECOND);
    endfunction

endpackage

// File: rtl/intack_gate.sv
module intack_gate (
    input  logic irq_lvl,
    input  logic ien,
    input  logic insn_bnd,
    input  logic idle,
    output logic accept
);
    // A level request counts only when sampled at a boundary with the flag set.
    always_comb begin
        accept = idle && insn_bnd && ien && irq_lvl;
    end
endmodule

// File: rtl/intack_fsm.sv
module intack_fsm
    import intack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       bus_rdy,
    output ack_state_t state,
    output logic       last_done
);
    ack_state_t state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (accept)  state_nx = ST_FIRST;
            ST_FIRST:  if (bus_rdy) state_nx = ST_SECOND;
            ST_SECOND: if (bus_rdy) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        last_done = (state == ST_SECOND) && bus_rdy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end
endmodule

// File: rtl/intack_vcap.sv
module intack_vcap #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [VEC_W-1:0] din,
    output logic [VEC_W-1:0] vec_data,
    output logic             vec_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_data  <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= cap;
            if (cap) begin
                vec_data <= din;
            end
        end
    end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
    import intack_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                irq_lvl,
    input  logic                ien,
    input  logic                insn_bnd,
    input  logic                bus_rdy,
    input  logic [VEC_W-1:0]    bus_data,
    output logic                bus_req,
    output logic [KIND_W-1:0]   bus_kind,
    output logic                bus_lock,
    output logic                bus_nocache,
    output logic                vec_valid,
    output logic [VEC_W-1:0]    vec_data
);
    ack_state_t state;
    logic       accept;
    logic       last_done;
    logic       active;

    intack_gate u_gate (
        .irq_lvl  (irq_lvl),
        .ien      (ien),
        .insn_bnd (insn_bnd),
        .idle     (state == ST_IDLE),
        .accept   (accept)
    );

    intack_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .bus_rdy   (bus_rdy),
        .state     (state),
        .last_done (last_done)
    );

    intack_vcap #(.VEC_W(VEC_W)) u_vcap (
        .clk       (clk),
        .rst       (rst),
        .cap       (last_done),
        .din       (bus_data),
        .vec_data  (vec_data),
        .vec_valid (vec_valid)
    );

    always_comb begin
        active      = in_ack(state);
        bus_req     = active;
        bus_lock    = active;
        bus_nocache = active;
        bus_kind    = kind_of(state);
    end
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_lvl,
    input logic             ien,
    input logic             insn_bnd,
    input logic             bus_rdy,
    input logic [VEC_W-1:0] bus_data,
    input logic             bus_req,
    input logic [1:0]       bus_kind,
    input logic             bus_lock,
    input logic             bus_nocache,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_data
);
    // R2: an accepted boundary request opens the first locked cycle
    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_kind == 2'd0 && insn_bnd && ien && irq_lvl) |=>
            (bus_req && bus_kind == 2'd1 && bus_lock));

    // R3: masked request leaves the block idle
    assert_masked_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_kind == 2'd0 && !ien) |=> (bus_kind == 2'd0 && !vec_valid));

    // R4: no boundary, no start
    assert_nobnd_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_kind == 2'd0 && !insn_bnd) |=> (!bus_req));

    // R5 / R6: first cycle holds through wait states regardless of the request
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_kind == 2'd1 && !bus_rdy) |=> (bus_kind == 2'd1 && bus_req));

    assert_advance_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_kind == 2'd1 && bus_rdy) |=> (bus_kind == 2'd2 && bus_req && bus_lock));

    // R7: lock covers every requested clock and drops after the final ready
    assert_lock_R7: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> bus_lock);

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_kind == 2'd2 && bus_rdy) |=> (!bus_lock && !bus_req));

    // R8: vector captured from the second cycle and pulsed for one clock
    assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_kind == 2'd2 && bus_rdy) |=>
            (vec_valid && vec_data == $past(bus_data)));

    assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid);

    // R9: acknowledge cycles are never cacheable
    assert_nocache_R9: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> bus_nocache);

    // R10: vector holds unless the second cycle completes
    assert_hold_vec_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_kind == 2'd2 && bus_rdy) |=> $stable(vec_data));
endmodule

bind intack_seq intack_seq_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_lvl     (irq_lvl),
    .ien         (ien),
    .insn_bnd    (insn_bnd),
    .bus_rdy     (bus_rdy),
    .bus_data    (bus_data),
    .bus_req     (bus_req),
    .bus_kind    (bus_kind),
    .bus_lock    (bus_lock),
    .bus_nocache (bus_nocache),
    .vec_valid   (vec_valid),
    .vec_data    (vec_data)
);

// File: tb/intack_seq_bench.sv
`timescale 1ns/100ps
module intack_seq_bench;
    localparam int VEC_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             irq_lvl = 1'b0;
    logic             ien = 1'b0;
    logic             insn_bnd = 1'b0;
    logic             bus_rdy = 1'b0;
    logic [VEC_W-1:0] bus_data = '0;
    logic             bus_req;
    logic [1:0]       bus_kind;
    logic             bus_lock;
    logic             bus_nocache;
    logic             vec_valid;
    logic [VEC_W-1:0] vec_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [VEC_W-1:0] last_vec = '0;

    always #2.5 clk = ~clk;

    intack_seq #(.VEC_W(VEC_W)) u_intack_seq (
        .clk(clk), .rst(rst), .irq_lvl(irq_lvl), .ien(ien), .insn_bnd(insn_bnd),
        .bus_rdy(bus_rdy), .bus_data(bus_data), .bus_req(bus_req),
        .bus_kind(bus_kind), .bus_lock(bus_lock), .bus_nocache(bus_nocache),
        .vec_valid(vec_valid), .vec_data(vec_data)
    );

    typedef struct packed {
        logic       f_ien;
        logic       f_irq;
        logic       f_bnd;
        logic [3:0] w1;
        logic [3:0] w2;
        logic [7:0] d1;
        logic [7:0] d2;
        logic       expect_ack;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TABLE [NV] = '{
        '{1'b1, 1'b1, 1'b1, 4'd0, 4'd0, 8'h11, 8'h20, 1'b1},
        '{1'b1, 1'b1, 1'b1, 4'd3, 4'd0, 8'h5A, 8'hA5, 1'b1},
        '{1'b0, 1'b1, 1'b1, 4'd0, 4'd0, 8'h00, 8'h77, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'd0, 4'd4, 8'hFF, 8'h00, 1'b1},
        '{1'b1, 1'b1, 1'b0, 4'd0, 4'd0, 8'h00, 8'h66, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'd2, 4'd2, 8'h00, 8'hFF, 1'b1},
        '{1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 8'h00, 8'h55, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'd1, 4'd1, 8'h33, 8'h3C, 1'b1},
        '{1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 8'h00, 8'h44, 1'b0}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_idle(input string tag);
        chk(bus_req == 1'b0, {tag, " bus_req"}, int'(bus_req), 0);
        chk(bus_kind == 2'd0, {tag, " bus_kind"}, int'(bus_kind), 0);
        chk(bus_lock == 1'b0, {tag, " bus_lock"}, int'(bus_lock), 0);
        chk(vec_valid == 1'b0, {tag, " vec_valid"}, int'(vec_valid), 0);
    endtask

    task automatic chk_cycle(input logic [1:0] kind, input string tag);
        chk(bus_req == 1'b1, {tag, " bus_req"}, int'(bus_req), 1);
        chk(bus_kind == kind, {tag, " bus_kind"}, int'(bus_kind), int'(kind));
        chk(bus_lock == 1'b1, {tag, " R7 bus_lock"}, int'(bus_lock), 1);
        chk(bus_nocache == 1'b1, {tag, " R9 bus_nocache"}, int'(bus_nocache), 1);
        chk(vec_valid == 1'b0, {tag, " vec_valid"}, int'(vec_valid), 0);
    endtask

    // Drives a boundary request and, if accepted, runs both cycles to completion.
    task automatic run_one(input vec_t v);
        ien = v.f_ien; irq_lvl = v.f_irq; insn_bnd = v.f_bnd;
        step();
        insn_bnd = 1'b0;
        irq_lvl = 1'b0;   // R5: request drops once the first cycle is under way
        ien = 1'b0;
        if (!v.expect_ack) begin
            for (int k = 0; k < 3; k++) begin
                chk_idle("R3/R4 ignored");
                chk(vec_data == last_vec, "R10 vec_data kept", int'(vec_data), int'(last_vec));
                step();
            end
            return;
        end
        chk_cycle(2'd1, "R2 first cycle");
        bus_data = v.d1;
        for (int k = 0; k < int'(v.w1); k++) begin
            step();
            chk_cycle(2'd1, "R6 first wait");
        end
        bus_rdy = 1'b1;
        step();
        bus_rdy = 1'b0;
        bus_data = ~v.d2;
        chk_cycle(2'd2, "R6 second cycle");
        chk(vec_data == last_vec, "R8 first data not captured", int'(vec_data), int'(last_vec));
        for (int k = 0; k < int'(v.w2); k++) begin
            step();
            chk_cycle(2'd2, "R7 second wait");
        end
        bus_data = v.d2;
        bus_rdy = 1'b1;
        step();
        bus_rdy = 1'b0;
        bus_data = ~v.d2;
        chk(vec_valid == 1'b1, "R8 vec_valid", int'(vec_valid), 1);
        chk(vec_data == v.d2, "R8 vec_data", int'(vec_data), int'(v.d2));
        chk(bus_lock == 1'b0, "R7 lock released", int'(bus_lock), 0);
        chk(bus_req == 1'b0, "R7 bus_req done", int'(bus_req), 0);
        last_vec = v.d2;
        step();
        chk(vec_valid == 1'b0, "R8 single pulse", int'(vec_valid), 0);
        chk(vec_data == last_vec, "R10 vec_data held", int'(vec_data), int'(last_vec));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step();
        step();
        chk_idle("R1 in reset");
        chk(vec_data == '0, "R1 vec_data", int'(vec_data), 0);
        chk(bus_nocache == 1'b0, "R1 bus_nocache", int'(bus_nocache), 0);
        rst = 1'b0;
        step();
        chk_idle("R1 after reset");

        for (int i = 0; i < NV; i++) begin
            run_one(TABLE[i]);
            step();
        end

        // R4: request high without a boundary, gone when the boundary arrives
        ien = 1'b1; irq_lvl = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk_idle("R4 no boundary");
        end
        irq_lvl = 1'b0; insn_bnd = 1'b1;
        step();
        insn_bnd = 1'b0; ien = 1'b0;
        chk_idle("R4 dropped before boundary");
        step();
        chk_idle("R4 still idle");

        // R5: boundary during the first cycle, with request still high, changes nothing
        ien = 1'b1; irq_lvl = 1'b1; insn_bnd = 1'b1;
        step();
        chk_cycle(2'd1, "R2 start again");
        step();
        chk_cycle(2'd1, "R5 hold with boundary");
        insn_bnd = 1'b0; irq_lvl = 1'b0; ien = 1'b0;
        bus_rdy = 1'b1; bus_data = 8'h9C;
        step();
        chk_cycle(2'd2, "R5 second after drop");
        bus_data = 8'hC9;
        step();
        bus_rdy = 1'b0;
        chk(vec_data == 8'hC9, "R5 vec_data", int'(vec_data), 32'hC9);
        chk(vec_valid == 1'b1, "R5 vec_valid", int'(vec_valid), 1);
        step();

        // R1: reset in the middle of the second cycle returns to idle
        ien = 1'b1; irq_lvl = 1'b1; insn_bnd = 1'b1;
        step();
        insn_bnd = 1'b0; bus_rdy = 1'b1;
        step();
        bus_rdy = 1'b0;
        chk_cycle(2'd2, "R6 before reset");
        rst = 1'b1;
        step();
        rst = 1'b0; irq_lvl = 1'b0; ien = 1'b0;
        chk_idle("R1 mid-sequence reset");
        chk(vec_data == '0, "R1 vec cleared", int'(vec_data), 0);
        step();
        chk_idle("R1 stays idle");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule